// File: doc/BRIEF.md
# Floating-Point Store Narrowing Unit

This block sits between an 80-bit floating-point register stack and the memory store path. It takes the top-of-stack value in extended precision (1 sign bit, a 15-bit exponent biased by 16383, and a 64-bit significand with an explicit integer bit) together with a flag that says whether that register is empty. It produces the value in single precision (8-bit exponent, bias 127), double precision (11-bit exponent, bias 1023) or unchanged extended precision. It also raises the exception flags that belong to a narrowing store, drives the C1 condition bit, and decides whether the store may be written and whether the stack may be popped.

A request is presented for one cycle on `st_valid`. All results appear one clock later, for one cycle, under `res_valid`. Finite values are rounded by a 2-bit control. Zeros, infinities and NaNs keep their class and lose low bits without rounding. Extended-format sources that are denormal are normalised before rounding.

Top module: `fpn_store_unit`

## Requirements
- R1: Every result appears on the clock edge after `st_valid` and lasts one cycle under `res_valid`. Format code 00 places a single-precision value in `res_data[31:0]`, code 01 places a double in `res_data[63:0]`, and codes 10/11 pass the 80-bit source through. All unused upper bits are zero. When `res_valid` is low, store, pop and flags are all zero.
- R2: Finite values are rounded on the discarded significand bits by `st_rmode` (00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero). The inexact flag (`res_flags[4]`) is set when any discarded bit is non-zero.
- R3: `res_c1` is 1 only when inexact is raised and the stored magnitude was rounded up; otherwise it is 0.
- R4: A rounded magnitude beyond the destination range sets overflow (`res_flags[2]`) and inexact. When overflow is masked, the stored value is infinity under nearest-even, under plus infinity for positive values and under minus infinity for negative values. In every other case it is the largest finite value of that sign.
- R5: When overflow is unmasked (`st_xmask[1]`=0), an overflowing store has `res_store_en` low.
- R6: A finite result that is tiny before rounding (biased destination exponent below 1) sets underflow (`res_flags[3]`) when it is inexact or when underflow is unmasked (`st_xmask[2]`=0). No denormal indication exists, and the denormal or rounded value is still stored.
- R7: Zeros and infinities keep their sign and class. A quiet NaN keeps its upper fraction bits by truncation. None of these raises a flag.
- R8: A signalling NaN stores its truncated fraction with the top fraction bit set. An unsupported encoding (integer bit clear with a non-zero exponent) stores the default NaN (sign 1, exponent all ones, top fraction bit only). Both set invalid (`res_flags[0]`) for formats 00/01 and never for the extended format.
- R9: An empty source sets invalid and stack fault (`res_flags[1]`), forces C1 to 0, and stores the default NaN of the selected format.
- R10: When invalid is unmasked (`st_xmask[0]`=0) and invalid is raised, `res_store_en` is low.
- R11: `res_pop` is high exactly when `st_pop_req` was set and the store is enabled.
- R12: A denormal extended source is normalised before narrowing. Its tiny value rounds to zero or to the smallest destination denormal according to the rounding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request for this cycle |
| st_src | input | 80 | Extended-precision source value |
| st_src_empty | input | 1 | Source register tag is empty |
| st_fmt | input | 2 | Destination format: 00 single, 01 double, 1x extended |
| st_rmode | input | 2 | Rounding control |
| st_xmask | input | 3 | Masks, 1 = masked: bit0 invalid, bit1 overflow, bit2 underflow |
| st_pop_req | input | 1 | Pop the stack after this store |
| res_valid | output | 1 | Result cycle |
| res_data | output | 80 | Narrowed value, zero-extended |
| res_store_en | output | 1 | Memory write may proceed |
| res_flags | output | 5 | bit0 invalid, bit1 stack fault, bit2 overflow, bit3 underflow, bit4 inexact |
| res_c1 | output | 1 | Condition bit C1 |
| res_pop | output | 1 | Pop strobe to the register stack |

## Verification
Two pairs of decisions can meet in a single result cycle. Write suppression and the pop strobe collide when an unmasked overflow or unmasked invalid arrives with a pop request. The stack-fault rule and the round-up report collide when an empty source carries a rounding mode that would otherwise round up. Directed cases put both halves into the same request. They judge the case by `res_store_en` and `res_pop` both being low, or by C1 staying 0 while stack fault and invalid are set. Carry-driven corners are also covered: rounding into overflow, and rounding a denormal up into the smallest normal.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  localparam int XP_EW   = 15;
  localparam int XP_MW   = 64;
  localparam int XP_BIAS = 16383;
  localparam int XP_W    = 1 + XP_EW + XP_MW;

  localparam int SP_EW = 8;
  localparam int SP_FW = 23;
  localparam int SP_BIAS = 127;
  localparam int DP_EW = 11;
  localparam int DP_FW = 52;
  localparam int DP_BIAS = 1023;

  localparam int EXP_SW = 18;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_FINITE,
    CL_INF,
    CL_QNAN,
    CL_SNAN,
    CL_UNSUP
  } vclass_e;

  typedef struct packed {
    logic pe;
    logic ue;
    logic oe;
    logic sf;
    logic ie;
  } xflags_t;

  // Leading-zero count of a 64-bit significand (64 for zero).
  function automatic logic [6:0] lzc64(input logic [63:0] v);
    logic [6:0] n;
    n = 7'd64;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) n = 7'(63 - i);
    end
    return n;
  endfunction

  // Increment decision from lsb, guard and sticky.
  function automatic logic round_inc(input rmode_e rm, input logic sgn,
                                     input logic lsb, input logic grd,
                                     input logic stk);
    case (rm)
      RM_NEAR: return grd & (stk | lsb);
      RM_DOWN: return sgn & (grd | stk);
      RM_UP:   return ~sgn & (grd | stk);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
  import fpn_pkg::*;
(
  input  logic [XP_W-1:0]         src,
  output vclass_e                 cls,
  output logic                    sign,
  output logic signed [EXP_SW-1:0] nexp,
  output logic [XP_MW-1:0]        nmant
);

  logic [XP_EW-1:0] ex;
  logic [XP_MW-1:0] mt;
  logic [6:0]       lz;
  logic [XP_EW-1:0] eff_e;

  assign sign  = src[XP_W-1];
  assign ex    = src[XP_W-2 -: XP_EW];
  assign mt    = src[XP_MW-1:0];
  assign lz    = lzc64(mt);
  assign eff_e = (ex == '0) ? XP_EW'(1) : ex;

  always_comb begin
    if (ex == '1) begin
      if (!mt[XP_MW-1])              cls = CL_UNSUP;
      else if (mt[XP_MW-2:0] == '0)  cls = CL_INF;
      else if (mt[XP_MW-2])          cls = CL_QNAN;
      else                           cls = CL_SNAN;
    end else if (ex == '0) begin
      cls = (mt == '0) ? CL_ZERO : CL_FINITE;
    end else begin
      cls = mt[XP_MW-1] ? CL_FINITE : CL_UNSUP;
    end
  end

  // Finite values are left-justified so that bit 63 is the leading one.
  always_comb begin
    if (cls == CL_FINITE) begin
      nmant = mt << lz;
      nexp  = EXP_SW'(int'(eff_e) - XP_BIAS - int'(lz));
    end else begin
      nmant = mt;
      nexp  = '0;
    end
  end

endmodule

// File: rtl/fpn_narrow_round.sv
module fpn_narrow_round
  import fpn_pkg::*;
#(
  parameter int EW   = 8,
  parameter int FW   = 23,
  parameter int BIAS = 127
) (
  input  vclass_e                  cls,
  input  logic                     src_empty,
  input  logic                     sign,
  input  logic signed [EXP_SW-1:0] nexp,
  input  logic [XP_MW-1:0]         nmant,
  input  rmode_e                   rmode,
  output logic [EW+FW:0]           value,
  output logic                     ovf,
  output logic                     tiny,
  output logic                     inexact,
  output logic                     roundup
);

  localparam int KW = FW + 1;
  localparam int SW = EXP_SW + FW;
  localparam logic [EW-1:0] EXP_ONES = '1;
  localparam logic [EW-1:0] EXP_MAXF = EXP_ONES - 1'b1;

  logic signed [EXP_SW-1:0] te;
  logic                     tiny_pre;
  logic [6:0]               sh;
  logic [XP_MW-1:0]         shifted;
  logic                     lost;
  logic [KW-1:0]            kept;
  logic                     grd, stk, inc;
  logic [KW:0]              rnd;
  logic [EXP_SW-1:0]        base;
  logic [SW-1:0]            sum;
  logic [EXP_SW-1:0]        efield;
  logic                     raw_ovf, to_inf;

  assign te       = nexp + EXP_SW'(BIAS);
  assign tiny_pre = (te < 18'sd1);

  always_comb begin
    if (!tiny_pre)           sh = 7'd0;
    else if (te < -18'sd63)  sh = 7'd65;
    else                     sh = 7'(18'sd1 - te);
  end

  always_comb begin
    if (sh >= 7'd64) begin
      shifted = '0;
      lost    = |nmant;
    end else begin
      shifted = nmant >> sh;
      lost    = |(nmant & ((64'd1 << sh) - 64'd1));
    end
  end

  assign kept = shifted[XP_MW-1 -: KW];
  assign grd  = shifted[XP_MW-1-KW];
  assign stk  = (|shifted[XP_MW-2-KW:0]) | lost;
  assign inc  = round_inc(rmode, sign, kept[0], grd, stk);
  assign rnd  = {1'b0, kept} + (KW+1)'(inc);

  // Exponent field plus rounded significand: a carry out of the fraction
  // or out of a denormal ripples into the exponent naturally.
  assign base    = tiny_pre ? '0 : EXP_SW'(te - 18'sd1);
  assign sum     = {base, {FW{1'b0}}} + SW'(rnd);
  assign efield  = sum[SW-1:FW];
  assign raw_ovf = !tiny_pre && (efield >= EXP_SW'(EXP_ONES));
  assign to_inf  = (rmode == RM_NEAR) || (rmode == RM_UP && !sign) ||
                   (rmode == RM_DOWN && sign);

  always_comb begin
    value   = '0;
    ovf     = 1'b0;
    tiny    = 1'b0;
    inexact = 1'b0;
    roundup = 1'b0;
    if (src_empty || cls == CL_UNSUP) begin
      value = {1'b1, EXP_ONES, 1'b1, {(FW-1){1'b0}}};
    end else begin
      case (cls)
        CL_ZERO: value = {sign, {EW{1'b0}}, {FW{1'b0}}};
        CL_INF:  value = {sign, EXP_ONES, {FW{1'b0}}};
        CL_QNAN: value = {sign, EXP_ONES, nmant[XP_MW-2 -: FW]};
        CL_SNAN: value = {sign, EXP_ONES, 1'b1, nmant[XP_MW-3 -: FW-1]};
        CL_FINITE: begin
          tiny = tiny_pre;
          if (raw_ovf) begin
            ovf     = 1'b1;
            inexact = 1'b1;
            roundup = to_inf;
            value   = to_inf ? {sign, EXP_ONES, {FW{1'b0}}}
                             : {sign, EXP_MAXF, {FW{1'b1}}};
          end else begin
            inexact = grd | stk;
            roundup = inc;
            value   = {sign, efield[EW-1:0], sum[FW-1:0]};
          end
        end
        default: value = {1'b1, EXP_ONES, 1'b1, {(FW-1){1'b0}}};
      endcase
    end
  end

endmodule

// File: rtl/fpn_store_flags.sv
module fpn_store_flags
  import fpn_pkg::*;
(
  input  vclass_e    cls,
  input  logic       src_empty,
  input  logic       fmt_ext,
  input  logic       ovf,
  input  logic       tiny,
  input  logic       inexact,
  input  logic       roundup,
  input  logic [2:0] xmask,
  output xflags_t    flags,
  output logic       store_ok,
  output logic       c1
);

  logic finite_ok;

  assign finite_ok = !src_empty && !fmt_ext && (cls == CL_FINITE);

  always_comb begin
    flags.sf = src_empty;
    flags.ie = src_empty ||
               (!fmt_ext && (cls == CL_SNAN || cls == CL_UNSUP));
    flags.oe = finite_ok && ovf;
    flags.ue = finite_ok && tiny && (inexact || !xmask[2]);
    flags.pe = finite_ok && inexact;
  end

  assign c1       = !src_empty && flags.pe && roundup;
  assign store_ok = !(flags.ie && !xmask[0]) && !(flags.oe && !xmask[1]);

endmodule

// File: rtl/fpn_store_unit.sv
module fpn_store_unit
  import fpn_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        st_valid,
  input  logic [79:0] st_src,
  input  logic        st_src_empty,
  input  logic [1:0]  st_fmt,
  input  logic [1:0]  st_rmode,
  input  logic [2:0]  st_xmask,
  input  logic        st_pop_req,
  output logic        res_valid,
  output logic [79:0] res_data,
  output logic        res_store_en,
  output logic [4:0]  res_flags,
  output logic        res_c1,
  output logic        res_pop
);

  localparam int NF = 2;
  localparam logic [XP_W-1:0] XP_INDEF = {1'b1, {XP_EW{1'b1}}, 2'b11, {(XP_MW-2){1'b0}}};

  vclass_e                  cls;
  logic                     src_sign;
  logic signed [EXP_SW-1:0] nexp;
  logic [XP_MW-1:0]         nmant;
  rmode_e                   rm;

  logic [63:0]   nar_val [NF];
  logic [NF-1:0] nar_ovf, nar_tiny, nar_inx, nar_up;

  // Named events for the checks below.
  logic    ev_ovf, ev_tiny, ev_inexact, ev_roundup, ev_store_ok, ev_c1;
  xflags_t ev_flags;
  logic    fmt_ext;
  logic [XP_W-1:0] sel_val;

  assign rm      = rmode_e'(st_rmode);
  assign fmt_ext = st_fmt[1];

  fpn_classify u_cls (
    .src   (st_src),
    .cls   (cls),
    .sign  (src_sign),
    .nexp  (nexp),
    .nmant (nmant)
  );

  for (genvar gi = 0; gi < NF; gi++) begin : g_fmt
    localparam int GEW   = (gi == 0) ? SP_EW   : DP_EW;
    localparam int GFW   = (gi == 0) ? SP_FW   : DP_FW;
    localparam int GBIAS = (gi == 0) ? SP_BIAS : DP_BIAS;
    logic [GEW+GFW:0] v;

    fpn_narrow_round #(.EW(GEW), .FW(GFW), .BIAS(GBIAS)) u_rnd (
      .cls       (cls),
      .src_empty (st_src_empty),
      .sign      (src_sign),
      .nexp      (nexp),
      .nmant     (nmant),
      .rmode     (rm),
      .value     (v),
      .ovf       (nar_ovf[gi]),
      .tiny      (nar_tiny[gi]),
      .inexact   (nar_inx[gi]),
      .roundup   (nar_up[gi])
    );
    assign nar_val[gi] = 64'(v);
  end

  assign ev_ovf     = nar_ovf[st_fmt[0]];
  assign ev_tiny    = nar_tiny[st_fmt[0]];
  assign ev_inexact = nar_inx[st_fmt[0]];
  assign ev_roundup = nar_up[st_fmt[0]];

  fpn_store_flags u_flg (
    .cls       (cls),
    .src_empty (st_src_empty),
    .fmt_ext   (fmt_ext),
    .ovf       (ev_ovf),
    .tiny      (ev_tiny),
    .inexact   (ev_inexact),
    .roundup   (ev_roundup),
    .xmask     (st_xmask),
    .flags     (ev_flags),
    .store_ok  (ev_store_ok),
    .c1        (ev_c1)
  );

  always_comb begin
    if (fmt_ext) sel_val = st_src_empty ? XP_INDEF : st_src;
    else         sel_val = {16'b0, nar_val[st_fmt[0]]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_store_en <= 1'b0;
      res_flags    <= '0;
      res_c1       <= 1'b0;
      res_pop      <= 1'b0;
    end else begin
      res_valid <= st_valid;
      if (st_valid) begin
        res_data     <= sel_val;
        res_store_en <= ev_store_ok;
        res_flags    <= ev_flags;
        res_c1       <= ev_c1;
        res_pop      <= st_pop_req && ev_store_ok;
      end else begin
        res_data     <= '0;
        res_store_en <= 1'b0;
        res_flags    <= '0;
        res_c1       <= 1'b0;
        res_pop      <= 1'b0;
      end
    end
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_store_en && !res_pop && res_flags == 5'b0)); // R1
  AST_C1_NEEDS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    res_c1 |-> res_flags[4]); // R3
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    res_flags[2] |-> res_flags[4]); // R4
  AST_UNMASKED_OVF_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && ev_ovf && !fmt_ext && !st_src_empty && !st_xmask[1]) |=> (res_valid && !res_store_en)); // R5
  AST_EXT_NO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && fmt_ext && !st_src_empty) |=> !res_flags[0]); // R8
  AST_EMPTY_C1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_src_empty) |=> (!res_c1 && res_flags[1] && res_flags[0])); // R9
  AST_UNMASKED_INV_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && ev_flags.ie && !st_xmask[0]) |=> !res_store_en); // R10
  AST_POP_WITH_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    res_pop |-> res_store_en); // R11

endmodule

// File: tb/fpn_store_unit_tb.sv
`timescale 1ns/100ps
module fpn_store_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [79:0] st_src = '0;
  logic        st_src_empty = 1'b0;
  logic [1:0]  st_fmt = 2'b00;
  logic [1:0]  st_rmode = 2'b00;
  logic [2:0]  st_xmask = 3'b111;
  logic        st_pop_req = 1'b0;
  logic        res_valid;
  logic [79:0] res_data;
  logic        res_store_en;
  logic [4:0]  res_flags;
  logic        res_c1;
  logic        res_pop;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [63:0] M_ONE = 64'h8000_0000_0000_0000;
  localparam logic [63:0] M_ALL = 64'hFFFF_FFFF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  fpn_store_unit u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_src(st_src),
    .st_src_empty(st_src_empty), .st_fmt(st_fmt), .st_rmode(st_rmode),
    .st_xmask(st_xmask), .st_pop_req(st_pop_req), .res_valid(res_valid),
    .res_data(res_data), .res_store_en(res_store_en), .res_flags(res_flags),
    .res_c1(res_c1), .res_pop(res_pop)
  );

  function automatic logic [79:0] xv(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  task automatic chk(input string tag, input logic [79:0] got, input logic [79:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Present one request, then sample at the following falling edge.
  task automatic apply(input logic [79:0] src, input logic emp, input logic [1:0] fmt,
                       input logic [1:0] rm, input logic [2:0] msk, input logic pop);
    @(negedge clk);
    st_src = src; st_src_empty = emp; st_fmt = fmt; st_rmode = rm;
    st_xmask = msk; st_pop_req = pop; st_valid = 1'b1;
    @(negedge clk);
    st_valid = 1'b0; st_pop_req = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [79:0] d, input logic st,
                            input logic [4:0] fl, input logic c1, input logic pp);
    chk({tag, " valid"}, 80'(res_valid), 80'(1'b1));
    chk({tag, " data"}, res_data, d);
    chk({tag, " store"}, 80'(res_store_en), 80'(st));
    chk({tag, " flags"}, 80'(res_flags), 80'(fl));
    chk({tag, " c1"}, 80'(res_c1), 80'(c1));
    chk({tag, " pop"}, 80'(res_pop), 80'(pp));
  endtask

  task automatic t_reset;
    chk("R1 reset valid", 80'(res_valid), 80'(0));
    chk("R1 reset store", 80'(res_store_en), 80'(0));
    chk("R1 reset pop", 80'(res_pop), 80'(0));
    chk("R1 reset flags", 80'(res_flags), 80'(0));
  endtask

  task automatic t_formats;
    apply(xv(0, 15'd16383, M_ONE), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R1 single 1.0", 80'h3F80_0000, 1, 5'h00, 0, 0);
    apply(xv(0, 15'd16383, M_ONE), 0, 2'b01, 2'b00, 3'b111, 0);
    expect_out("R1 double 1.0", 80'h3FF0_0000_0000_0000, 1, 5'h00, 0, 0);
    apply(xv(1, 15'd16390, 64'hC123_4567_89AB_CDEF), 0, 2'b10, 2'b11, 3'b111, 0);
    expect_out("R1 extended pass", xv(1, 15'd16390, 64'hC123_4567_89AB_CDEF), 1, 5'h00, 0, 0);
    @(negedge clk);
    chk("R1 idle after op", 80'(res_valid), 80'(0));
  endtask

  task automatic t_rounding;
    logic [63:0] half = 64'h8000_0080_0000_0000;
    apply(xv(0, 15'd16383, half), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R2 tie even down", 80'h3F80_0000, 1, 5'h10, 0, 0);
    apply(xv(0, 15'd16383, half), 0, 2'b00, 2'b10, 3'b111, 0);
    expect_out("R3 up rounds up", 80'h3F80_0001, 1, 5'h10, 1, 0);
    apply(xv(0, 15'd16383, half), 0, 2'b00, 2'b11, 3'b111, 0);
    expect_out("R2 toward zero", 80'h3F80_0000, 1, 5'h10, 0, 0);
    apply(xv(1, 15'd16383, half), 0, 2'b00, 2'b01, 3'b111, 0);
    expect_out("R3 down negative", 80'hBF80_0001, 1, 5'h10, 1, 0);
    apply(xv(0, 15'd16383, 64'h8000_0180_0000_0000), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R2 tie even up", 80'h3F80_0002, 1, 5'h10, 1, 0);
    apply(xv(0, 15'd16383, half), 0, 2'b01, 2'b00, 3'b111, 0);
    expect_out("R2 double exact", 80'h3FF0_0000_1000_0000, 1, 5'h00, 0, 0);
  endtask

  task automatic t_overflow;
    apply(xv(0, 15'd16511, M_ONE), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R4 near to inf", 80'h7F80_0000, 1, 5'h14, 1, 0);
    apply(xv(0, 15'd16511, M_ONE), 0, 2'b00, 2'b11, 3'b111, 0);
    expect_out("R4 zero to max", 80'h7F7F_FFFF, 1, 5'h14, 0, 0);
    apply(xv(1, 15'd16511, M_ONE), 0, 2'b00, 2'b10, 3'b111, 0);
    expect_out("R4 neg up max", 80'hFF7F_FFFF, 1, 5'h14, 0, 0);
    apply(xv(1, 15'd16511, M_ONE), 0, 2'b00, 2'b01, 3'b111, 0);
    expect_out("R4 neg down inf", 80'hFF80_0000, 1, 5'h14, 1, 0);
    apply(xv(0, 15'd16510, M_ALL), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R4 carry overflow", 80'h7F80_0000, 1, 5'h14, 1, 0);
    apply(xv(0, 15'd16510, M_ALL), 0, 2'b00, 2'b11, 3'b111, 0);
    expect_out("R4 no carry no ovf", 80'h7F7F_FFFF, 1, 5'h10, 0, 0);
    apply(xv(0, 15'd16511, M_ONE), 0, 2'b00, 2'b00, 3'b101, 1);
    chk("R5 unmasked ovf store", 80'(res_store_en), 80'(0));
    chk("R5 unmasked ovf flags", 80'(res_flags), 80'(5'h14));
    chk("R11 no pop on ovf", 80'(res_pop), 80'(0));
  endtask

  task automatic t_underflow;
    apply(xv(0, 15'd16256, M_ONE), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R6 tiny exact masked", 80'h0040_0000, 1, 5'h00, 0, 0);
    apply(xv(0, 15'd16256, M_ONE), 0, 2'b00, 2'b00, 3'b011, 0);
    expect_out("R6 tiny exact unmasked", 80'h0040_0000, 1, 5'h08, 0, 0);
    apply(xv(0, 15'd16256, 64'h8000_0000_0000_0001), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R6 tiny inexact", 80'h0040_0000, 1, 5'h18, 0, 0);
    apply(xv(0, 15'd16256, M_ALL), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R6 denorm to normal", 80'h0080_0000, 1, 5'h18, 1, 0);
    apply(xv(0, 15'd0, 64'h1), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R12 src denorm near", 80'h0, 1, 5'h18, 0, 0);
    apply(xv(0, 15'd0, 64'h1), 0, 2'b00, 2'b10, 3'b111, 0);
    expect_out("R12 src denorm up", 80'h1, 1, 5'h18, 1, 0);
  endtask

  task automatic t_specials;
    apply(xv(1, 15'd0, 64'h0), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R7 neg zero", 80'h8000_0000, 1, 5'h00, 0, 0);
    apply(xv(0, 15'h7FFF, M_ONE), 0, 2'b00, 2'b10, 3'b111, 0);
    expect_out("R7 inf", 80'h7F80_0000, 1, 5'h00, 0, 0);
    apply(xv(0, 15'h7FFF, 64'hC000_0000_0000_0000), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R7 qnan", 80'h7FC0_0000, 1, 5'h00, 0, 0);
    apply(xv(0, 15'h7FFF, 64'hA000_0000_0000_0000), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R8 snan single", 80'h7FE0_0000, 1, 5'h01, 0, 0);
    apply(xv(0, 15'h7FFF, 64'hA000_0000_0000_0000), 0, 2'b01, 2'b00, 3'b111, 0);
    expect_out("R8 snan double", 80'h7FFC_0000_0000_0000, 1, 5'h01, 0, 0);
    apply(xv(0, 15'h7FFF, 64'hA000_0000_0000_0000), 0, 2'b10, 2'b00, 3'b111, 0);
    expect_out("R8 snan extended", xv(0, 15'h7FFF, 64'hA000_0000_0000_0000), 1, 5'h00, 0, 0);
    apply(xv(0, 15'd16383, 64'h4000_0000_0000_0000), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R8 unsupported", 80'hFFC0_0000, 1, 5'h01, 0, 0);
    apply(xv(0, 15'h7FFF, 64'hA000_0000_0000_0000), 0, 2'b00, 2'b00, 3'b110, 1);
    expect_out("R10 unmasked invalid", 80'h7FE0_0000, 0, 5'h01, 0, 0);
  endtask

  task automatic t_empty_pop;
    apply(xv(0, 15'd16383, 64'h8000_0080_0000_0000), 1, 2'b00, 2'b10, 3'b111, 1);
    expect_out("R9 empty masked", 80'hFFC0_0000, 1, 5'h03, 0, 1);
    apply(xv(0, 15'd16383, M_ONE), 1, 2'b01, 2'b00, 3'b110, 1);
    expect_out("R9 empty unmasked", 80'hFFF8_0000_0000_0000, 0, 5'h03, 0, 0);
    apply(xv(0, 15'd16383, M_ONE), 0, 2'b00, 2'b00, 3'b111, 1);
    expect_out("R11 pop on store", 80'h3F80_0000, 1, 5'h00, 0, 1);
    apply(xv(0, 15'd16383, M_ONE), 0, 2'b00, 2'b00, 3'b111, 0);
    expect_out("R11 no pop request", 80'h3F80_0000, 1, 5'h00, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_rounding();
    t_overflow();
    t_underflow();
    t_specials();
    t_empty_pop();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule